// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block walks one set of a four-way data cache after a cache error has been reported and judges what it finds there. A single start pulse supplies a set index and says whether the data array should be swept as well. The block then reads the tag of every way through an external read port. For each way it decodes the five-bit coherence state and checks the two parity bits that guard the physical tag. It also rebuilds the line's physical address and records a coarse state class. When the data sweep is requested, four doublewords are read per way. An attached ECC checker returns a syndrome for each one, and the block sorts that syndrome into a single-bit or a multi-bit fault.

The verdicts are collected in a sticky four-bit error mask. The mask is cleared when a run starts, and a one-cycle done pulse marks the moment it is final. The read port is combinational. The block presents a way, an offset, the set index and a tag-or-data select, and the array and ECC checker answer within the same cycle. The bank and set numbers decoded from the index are also presented for diagnostics.

Top module: `dcache_tag_checker`

## Requirements
- R1: After reset, busy_o, done_o, rd_en_o and err_o are all 0.
- R2: A start pulse seen while idle captures idx_i and with_data_i. The block then reads ways 0 to 3 in ascending order. Each tag read (rd_data_o=0, rd_off_o=0) is followed, when with_data_i was 1, by data reads of offsets 0 to 3 of that way (rd_data_o=1). rd_idx_o shows the captured index throughout the run, and start_i is ignored while busy_o is 1.
- R3: The coherence state of a way is tag-high bits 29:25. cls_o[2w+1:2w] for way w gives its class: 0 for any code other than the five valid ones, 1 for 0x0F, 2 for 0x13 and 0x16, and 3 for 0x19 and 0x1C.
- R4: A way whose state code is not one of 0x0F, 0x13, 0x16, 0x19 or 0x1C sets err_o bit 3 (tag state). This includes 0x00.
- R5: For a way with a valid code, err_o bit 2 (tag address) is set when tag-low bit 11 differs from the XOR of tag-low bits 39:26, or when tag-low bit 10 differs from the XOR of bits 25:13. Tag parity of a way with an invalid code has no effect on bit 2.
- R6: pa_o[40w+39:40w] holds {tag-low bits 39:13, the 8-bit set index, five zero bits} for way w.
- R7: bank_o is {index bit 7, index bit 0} and set_o is index bits 6:1, taken from the captured index.
- R8: During a data read, a syndrome with exactly one bit set sets err_o bit 1 (single-bit). Any other non-zero syndrome sets err_o bit 0 (multi-bit), and a zero syndrome sets nothing.
- R9: err_o is cleared at the start of a run, and its bits only accumulate during the run. done_o is high for exactly one cycle, the cycle after the last read. That is 5 cycles after the start edge without the data sweep and 21 cycles with it. All outputs then hold until the next start.
- R10: When with_data_i was 0, no data reads are issued and the syndrome input has no effect on err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check run (honoured only while idle) |
| idx_i | input | 8 | Set index (address bits 12:5) |
| with_data_i | input | 1 | Also sweep the four data doublewords of each way |
| rd_en_o | output | 1 | A read of the array is presented this cycle |
| rd_data_o | output | 1 | 1 selects a data read, 0 a tag read |
| rd_way_o | output | 2 | Way being read |
| rd_idx_o | output | 8 | Set index being read |
| rd_off_o | output | 2 | Doubleword offset for data reads |
| rd_tag_hi_i | input | 32 | Tag-high word returned by the array |
| rd_tag_lo_i | input | 64 | Tag-low word returned by the array |
| rd_syn_i | input | 8 | Syndrome of the doubleword from the attached ECC checker |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: results are final |
| err_o | output | 4 | Sticky flags: tag state, tag address, single-bit, multi-bit |
| pa_o | output | 160 | Rebuilt physical address of each way |
| cls_o | output | 8 | Two-bit state class of each way |
| bank_o | output | 2 | Bank number from the captured index |
| set_o | output | 6 | Set number from the captured index |

## Verification
The assertions assume that start_i is a clean synchronous level. They also assume the read port answers in the same cycle with stable values, because the port is combinational and flags are folded in at the edge ending each read. The bench drives every input on the falling edge and serves tag words and syndromes from a small array model indexed by rd_way_o and rd_off_o. It raises start_i only for a single cycle, with one deliberate pulse during a run to probe that such pulses are ignored. Tag words are built with computed parity before selected bits are flipped, so each parity fault is a known, intended one.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    // Tag-high field holding the coherence state
    localparam int STATE_MSB   = 29;
    localparam int STATE_LSB   = 25;
    localparam int STATE_W     = STATE_MSB - STATE_LSB + 1;

    // Address layout
    localparam int LINE_OFS_W  = 5;
    localparam int IDX_W       = 8;
    localparam int PTAG_LSB    = IDX_W + LINE_OFS_W;
    localparam int PTAG_MSB    = 39;
    localparam int PTAG_SPLIT  = 26;
    localparam int PAR_UP_POS  = 11;
    localparam int PAR_LOW_POS = 10;
    localparam int PA_W        = PTAG_MSB + 1;

    localparam int TAG_HI_W    = 32;
    localparam int TAG_LO_W    = 64;
    localparam int SYN_W       = 8;

    // Legal coherence codes
    localparam logic [STATE_W-1:0] ST_SHR    = 5'h0F;
    localparam logic [STATE_W-1:0] ST_NC_CLN = 5'h13;
    localparam logic [STATE_W-1:0] ST_NC_DRT = 5'h19;
    localparam logic [STATE_W-1:0] ST_CO_CLN = 5'h16;
    localparam logic [STATE_W-1:0] ST_CO_DRT = 5'h1C;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_SHR   = 2'd1,
        CLS_CLEAN = 2'd2,
        CLS_DIRTY = 2'd3
    } line_cls_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TAG  = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic bad_state;
        logic bad_ptag;
        logic one_bit;
        logic multi_bit;
    } err_flags_t;

    function automatic line_cls_e cls_of(input logic [STATE_W-1:0] code);
        line_cls_e c;
        case (code)
            ST_SHR:               c = CLS_SHR;
            ST_NC_CLN, ST_CO_CLN: c = CLS_CLEAN;
            ST_NC_DRT, ST_CO_DRT: c = CLS_DIRTY;
            default:              c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dtc_state_decode.sv
module dtc_state_decode
    import dtc_pkg::*;
(
    input  logic [TAG_HI_W-1:0] tag_hi,
    output logic                legal,
    output line_cls_e           cls
);
    logic [STATE_W-1:0] code;

    always_comb begin
        code  = tag_hi[STATE_MSB:STATE_LSB];
        cls   = cls_of(code);
        legal = (cls != CLS_NONE);
    end
endmodule

// File: rtl/dtc_ptag_check.sv
module dtc_ptag_check
    import dtc_pkg::*;
(
    input  logic [TAG_LO_W-1:0] tag_lo,
    input  logic                legal,
    output logic                bad
);
    logic upper_par;
    logic lower_par;

    always_comb begin
        upper_par = ^tag_lo[PTAG_MSB:PTAG_SPLIT];
        lower_par = ^tag_lo[PTAG_SPLIT-1:PTAG_LSB];
        bad = legal && ((upper_par != tag_lo[PAR_UP_POS]) ||
                        (lower_par != tag_lo[PAR_LOW_POS]));
    end
endmodule

// File: rtl/dtc_syndrome_class.sv
module dtc_syndrome_class
    import dtc_pkg::*;
(
    input  logic [SYN_W-1:0] syn,
    input  logic             en,
    output logic             one_bit,
    output logic             multi_bit
);
    logic nonzero;
    logic single;

    always_comb begin
        nonzero   = |syn;
        single    = nonzero &&
                    ((syn & (syn - {{(SYN_W-1){1'b0}}, 1'b1})) == '0);
        one_bit   = en && single;
        multi_bit = en && nonzero && !single;
    end
endmodule

// File: rtl/dcache_tag_checker.sv
module dcache_tag_checker
    import dtc_pkg::*;
#(
    parameter int NWAYS = 4,
    parameter int NOFFS = 4,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int OFF_W = (NOFFS > 1) ? $clog2(NOFFS) : 1
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic                      with_data_i,
    output logic                      rd_en_o,
    output logic                      rd_data_o,
    output logic [WAY_W-1:0]          rd_way_o,
    output logic [IDX_W-1:0]          rd_idx_o,
    output logic [OFF_W-1:0]          rd_off_o,
    input  logic [TAG_HI_W-1:0]       rd_tag_hi_i,
    input  logic [TAG_LO_W-1:0]       rd_tag_lo_i,
    input  logic [SYN_W-1:0]          rd_syn_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [3:0]                err_o,
    output logic [NWAYS*PA_W-1:0]     pa_o,
    output logic [NWAYS*2-1:0]        cls_o,
    output logic [1:0]                bank_o,
    output logic [5:0]                set_o
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NWAYS - 1);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(NOFFS - 1);

    phase_e             phase_q;
    logic [WAY_W-1:0]   way_q;
    logic [OFF_W-1:0]   off_q;
    logic [IDX_W-1:0]   idx_q;
    logic               sweep_q;
    err_flags_t         err_q;
    logic [PA_W-1:0]    pa_q  [NWAYS];
    line_cls_e          cls_q [NWAYS];

    logic       legal;
    line_cls_e  cls_now;
    logic       ptag_bad;
    logic       one_bit;
    logic       multi_bit;
    logic       in_tag;
    logic       in_data;

    assign in_tag  = (phase_q == PH_TAG);
    assign in_data = (phase_q == PH_DATA);

    dtc_state_decode u_state (
        .tag_hi (rd_tag_hi_i),
        .legal  (legal),
        .cls    (cls_now)
    );

    dtc_ptag_check u_ptag (
        .tag_lo (rd_tag_lo_i),
        .legal  (legal),
        .bad    (ptag_bad)
    );

    dtc_syndrome_class u_syn (
        .syn       (rd_syn_i),
        .en        (in_data),
        .one_bit   (one_bit),
        .multi_bit (multi_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            way_q   <= '0;
            off_q   <= '0;
            idx_q   <= '0;
            sweep_q <= 1'b0;
            err_q   <= '0;
            for (int w = 0; w < NWAYS; w++) begin
                pa_q[w]  <= '0;
                cls_q[w] <= CLS_NONE;
            end
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_DONE: begin
                    if (start_i) begin
                        idx_q   <= idx_i;
                        sweep_q <= with_data_i;
                        err_q   <= '0;
                        way_q   <= '0;
                        off_q   <= '0;
                        phase_q <= PH_TAG;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_TAG: begin
                    err_q.bad_state <= err_q.bad_state | !legal;
                    err_q.bad_ptag  <= err_q.bad_ptag | ptag_bad;
                    pa_q[way_q]     <= {rd_tag_lo_i[PTAG_MSB:PTAG_LSB], idx_q,
                                        {LINE_OFS_W{1'b0}}};
                    cls_q[way_q]    <= cls_now;
                    if (sweep_q) begin
                        off_q   <= '0;
                        phase_q <= PH_DATA;
                    end else if (way_q == LAST_WAY) begin
                        phase_q <= PH_DONE;
                    end else begin
                        way_q <= way_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    err_q.one_bit   <= err_q.one_bit | one_bit;
                    err_q.multi_bit <= err_q.multi_bit | multi_bit;
                    if (off_q == LAST_OFF) begin
                        off_q <= '0;
                        if (way_q == LAST_WAY) begin
                            phase_q <= PH_DONE;
                        end else begin
                            way_q   <= way_q + 1'b1;
                            phase_q <= PH_TAG;
                        end
                    end else begin
                        off_q <= off_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign rd_en_o   = in_tag | in_data;
    assign rd_data_o = in_data;
    assign rd_way_o  = way_q;
    assign rd_off_o  = off_q;
    assign rd_idx_o  = idx_q;
    assign busy_o    = in_tag | in_data;
    assign done_o    = (phase_q == PH_DONE);
    assign err_o     = err_q;
    assign bank_o    = {idx_q[IDX_W-1], idx_q[0]};
    assign set_o     = idx_q[IDX_W-2:1];

    for (genvar g = 0; g < NWAYS; g++) begin : g_way_out
        assign pa_o[g*PA_W +: PA_W] = pa_q[g];
        assign cls_o[g*2 +: 2]      = cls_q[g];
    end
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
    parameter int WAY_W = 2,
    parameter int IDX_W = 8
)(
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             done_o,
    input logic             rd_en_o,
    input logic             rd_data_o,
    input logic [WAY_W-1:0] rd_way_o,
    input logic [IDX_W-1:0] rd_idx_o,
    input logic [3:0]       err_o
);
    // R1: reads only appear inside a run
    a_r1_read_in_run: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> busy_o);

    // R2: every run opens with the tag read of way 0
    a_r2_tag_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (!rd_data_o && rd_way_o == '0));

    // R2: index held for the whole run
    a_r2_idx_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_idx_o));

    // R9: flags only accumulate while running
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ((err_o & $past(err_o)) == $past(err_o)));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: done directly follows a run
    a_r9_done_after_run: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o && !rd_en_o));
endmodule

bind dcache_tag_checker dtc_checker #(.WAY_W(WAY_W), .IDX_W(dtc_pkg::IDX_W)) u_dtc_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_en_o   (rd_en_o),
    .rd_data_o (rd_data_o),
    .rd_way_o  (rd_way_o),
    .rd_idx_o  (rd_idx_o),
    .err_o     (err_o)
);

// File: tb/dcache_tag_checker_tb.sv
`timescale 1ns/1ps
module dcache_tag_checker_tb_top;

    typedef struct packed {
        logic [3:0]   err;
        logic [159:0] pa;
        logic [7:0]   cls;
        logic [1:0]   bank;
        logic [5:0]   set;
    } res_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [7:0]   idx_i = '0;
    logic         with_data_i = 1'b0;
    logic         rd_en_o, rd_data_o;
    logic [1:0]   rd_way_o, rd_off_o;
    logic [7:0]   rd_idx_o;
    logic [31:0]  rd_tag_hi_i;
    logic [63:0]  rd_tag_lo_i;
    logic [7:0]   rd_syn_i;
    logic         busy_o, done_o;
    logic [3:0]   err_o;
    logic [159:0] pa_o;
    logic [7:0]   cls_o;
    logic [1:0]   bank_o;
    logic [5:0]   set_o;

    logic [31:0]  tb_hi  [4];
    logic [63:0]  tb_lo  [4];
    logic [7:0]   tb_syn [4][4];

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc = 0;

    logic [12:0] rd_q  [$];
    res_t        res_q [$];

    always #2.5 clk = ~clk;

    assign rd_tag_hi_i = tb_hi[rd_way_o];
    assign rd_tag_lo_i = tb_lo[rd_way_o];
    assign rd_syn_i    = tb_syn[rd_way_o][rd_off_o];

    dcache_tag_checker dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .idx_i(idx_i),
        .with_data_i(with_data_i), .rd_en_o(rd_en_o), .rd_data_o(rd_data_o),
        .rd_way_o(rd_way_o), .rd_idx_o(rd_idx_o), .rd_off_o(rd_off_o),
        .rd_tag_hi_i(rd_tag_hi_i), .rd_tag_lo_i(rd_tag_lo_i), .rd_syn_i(rd_syn_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .pa_o(pa_o),
        .cls_o(cls_o), .bank_o(bank_o), .set_o(set_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_cls(input logic [4:0] c);
        case (c)
            5'h0F:        return 2'd1;
            5'h13, 5'h16: return 2'd2;
            5'h19, 5'h1C: return 2'd3;
            default:      return 2'd0;
        endcase
    endfunction

    // Build a tag with correct parity, then flip the requested parity bits
    task automatic set_way(input int w, input logic [4:0] code, input logic [26:0] ptag,
                           input bit flip_up, input bit flip_low);
        logic [63:0] lo;
        lo = 64'hABCD_0000_0000_0000;
        lo[39:13] = ptag;
        lo[11] = (^lo[39:26]) ^ flip_up;
        lo[10] = (^lo[25:13]) ^ flip_low;
        tb_lo[w] = lo;
        tb_hi[w] = 32'h8000_1234;
        tb_hi[w][29:25] = code;
    endtask

    task automatic clear_syn();
        for (int w = 0; w < 4; w++)
            for (int o = 0; o < 4; o++)
                tb_syn[w][o] = 8'h00;
    endtask

    // Driver: queue expectations, launch, time the run
    task automatic run_case(input logic [7:0] idx, input bit wd, input bit poke);
        res_t r;
        int n;
        r = '0;
        for (int w = 0; w < 4; w++) begin
            logic [4:0] code;
            bit ok;
            code = tb_hi[w][29:25];
            ok = (exp_cls(code) != 2'd0);
            if (!ok) r.err[3] = 1'b1;
            if (ok && ((tb_lo[w][11] != ^tb_lo[w][39:26]) ||
                       (tb_lo[w][10] != ^tb_lo[w][25:13]))) r.err[2] = 1'b1;
            r.pa[w*40 +: 40] = {tb_lo[w][39:13], idx, 5'b0};
            r.cls[w*2 +: 2]  = exp_cls(code);
            rd_q.push_back({idx, 1'b0, 2'(w), 2'd0});
            if (wd) begin
                for (int o = 0; o < 4; o++) begin
                    if ($countones(tb_syn[w][o]) == 1) r.err[1] = 1'b1;
                    else if (tb_syn[w][o] != 8'h00) r.err[0] = 1'b1;
                    rd_q.push_back({idx, 1'b1, 2'(w), 2'(o)});
                end
            end
        end
        r.bank = {idx[7], idx[0]};
        r.set  = idx[6:1];
        res_q.push_back(r);

        @(negedge clk);
        start_i = 1'b1; idx_i = idx; with_data_i = wd;
        @(negedge clk);
        n = 1;
        start_i = 1'b0; idx_i = ~idx; with_data_i = ~wd;
        check(busy_o == 1'b1, "R2", "busy after start", 160'(busy_o), 160'd1);
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) start_i = 1'b1;   // R2: must be ignored
            if (poke && n == 3) start_i = 1'b0;
        end
        check(n == (wd ? 21 : 5), "R9", "done latency", 160'(n), 160'(wd ? 21 : 5));
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R9", "done single pulse",
              160'({done_o, busy_o}), 160'd0);
        check(err_o == r.err, "R9", "err held after done", 160'(err_o), 160'(r.err));
        check(rd_q.size() == 0, "R10", "all expected reads issued", 160'(rd_q.size()), 160'd0);
    endtask

    // Monitor: read sequence and results
    always @(negedge clk) begin
        if (!rst && rd_en_o) begin
            if (rd_q.size() == 0) begin
                check(1'b0, "R10", "unexpected read", 160'({rd_data_o, rd_way_o, rd_off_o}), 160'd0);
            end else begin
                logic [12:0] e;
                e = rd_q.pop_front();
                check({rd_idx_o, rd_data_o, rd_way_o, rd_off_o} == e, "R2", "read order",
                      160'({rd_idx_o, rd_data_o, rd_way_o, rd_off_o}), 160'(e));
            end
        end
        if (!rst && done_o) begin
            if (res_q.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 160'd1, 160'd0);
            end else begin
                res_t e;
                e = res_q.pop_front();
                check(err_o == e.err, "R4 R5 R8", "error mask", 160'(err_o), 160'(e.err));
                check(pa_o == e.pa, "R6", "physical addresses", pa_o, e.pa);
                check(cls_o == e.cls, "R3", "state classes", 160'(cls_o), 160'(e.cls));
                check(bank_o == e.bank, "R7", "bank", 160'(bank_o), 160'(e.bank));
                check(set_o == e.set, "R7", "set", 160'(set_o), 160'(e.set));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_syn();
        for (int w = 0; w < 4; w++) set_way(w, 5'h00, 27'h0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy_o, done_o, rd_en_o, err_o} == 7'd0, "R1", "reset outputs",
              160'({busy_o, done_o, rd_en_o, err_o}), 160'd0);
        rst = 1'b0;
        @(negedge clk);
        check({busy_o, done_o, rd_en_o} == 3'd0, "R1", "idle after reset",
              160'({busy_o, done_o, rd_en_o}), 160'd0);

        // Case 1: all legal, clean parity, tag-only (R3, R6, R7)
        set_way(0, 5'h0F, 27'h1234567, 0, 0);
        set_way(1, 5'h13, 27'h7FFFFFF, 0, 0);
        set_way(2, 5'h19, 27'h0000001, 0, 0);
        set_way(3, 5'h16, 27'h2AAAAAA, 0, 0);
        run_case(8'hA5, 1'b0, 1'b0);

        // Case 2: illegal codes, upper parity flip, single-bit syndrome (R4, R5, R8)
        set_way(0, 5'h1C, 27'h0ABCDEF, 0, 0);
        set_way(1, 5'h00, 27'h0000000, 0, 0);
        set_way(2, 5'h0F, 27'h5555555, 1, 0);
        set_way(3, 5'h1F, 27'h3333333, 0, 0);
        tb_syn[0][1] = 8'h04;
        run_case(8'h3C, 1'b1, 1'b0);

        // Case 3: bad parity on an invalid line only; multi-bit syndrome; stray start (R5, R2, R8)
        clear_syn();
        set_way(0, 5'h13, 27'h1111111, 0, 0);
        set_way(1, 5'h00, 27'h2222222, 1, 1);
        set_way(2, 5'h19, 27'h4444444, 0, 0);
        set_way(3, 5'h1C, 27'h6666666, 0, 0);
        tb_syn[3][3] = 8'h03;
        run_case(8'h01, 1'b1, 1'b1);

        // Case 4: lower parity flip; syndromes present but no sweep (R5, R10, R7)
        tb_syn[0][0] = 8'h80;
        tb_syn[2][1] = 8'hFF;
        set_way(0, 5'h16, 27'h0F0F0F0, 0, 0);
        set_way(1, 5'h0F, 27'h1357913, 0, 1);
        set_way(2, 5'h13, 27'h2468ACE, 0, 0);
        set_way(3, 5'h19, 27'h7654321, 0, 0);
        run_case(8'h81, 1'b0, 1'b0);

        // Case 5: near-legal code and both faults in the sweep, checks clear at start (R4, R8, R9)
        clear_syn();
        set_way(0, 5'h17, 27'h0000F00, 0, 0);
        set_way(1, 5'h0F, 27'h0000F01, 0, 0);
        set_way(2, 5'h0F, 27'h0000F02, 0, 0);
        set_way(3, 5'h0E, 27'h0000F03, 0, 0);
        tb_syn[1][2] = 8'h01;
        tb_syn[2][0] = 8'h90;
        run_case(8'hFE, 1'b1, 1'b0);

        // Case 6: clean sweep after faulty runs, mask must be empty (R9)
        clear_syn();
        for (int w = 0; w < 4; w++) set_way(w, 5'h1C, 27'(w * 27'h0123457), 0, 0);
        run_case(8'h40, 1'b1, 1'b0);

        repeat (2) @(negedge clk);
        check(res_q.size() == 0, "R9", "all results seen", 160'(res_q.size()), 160'd0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule